// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the write-command interpreter of a parallel NOR flash device in synthesizable form. Bus write cycles arrive as a single-cycle strobe with an address and a data byte. The block decodes them into unlock sequences, the standard program command, entry into and exit from a persistent fast-program (unlock-bypass) mode, and entry into and exit from a read-only serial-number overlay. Programming is applied to a small internal array after a fixed internal busy period. During that period a ready output is held low and every bus write is discarded.

Programming can only clear bits. The stored word becomes the old contents ANDed with the written data, so a zero never returns to one. A separate read port returns the addressed array word one cycle later. While the overlay is selected, the same port returns one of sixteen serial bytes instead.

Top module: `nor_cmd_seq`

## Requirements
- R1: A standard program takes four writes. These are AAh at command address 555h, 55h at 2AAh, A0h at 555h, and then the target address and data. The word at the target, taken from the low ARR_AW address bits, is then programmed.
- R2: The array powers up erased, with every word FFh. A program stores old AND new, so programming FFh over a word leaves it unchanged.
- R3: The ready output is high while idle. It goes low on the cycle after the address/data write and stays low for exactly BUSY_CYCLES cycles (default 8). The programmed value is readable once ready is high again.
- R4: While ready is low, every bus write is ignored, including a complete command prefix. The block then returns to read mode.
- R5: AAh at 555h, 55h at 2AAh and 20h at 555h enter bypass mode. In bypass mode every program is two writes, A0h and then the address/data. The mode persists across programs.
- R6: In bypass mode, a first write other than A0h or 90h is ignored and the block stays in bypass. 90h followed by 00h returns the block to read mode. 90h followed by any other value stays in bypass. After the exit, A0h plus address/data programs nothing.
- R7: In read mode, a write that does not match the next expected step of a command aborts to read mode. The step can fail on the data or on the address. The following address/data write programs nothing.
- R8: Reset returns ready high at once. It abandons a program in progress without changing the array, and it leaves bypass mode.
- R9: AAh at 555h, 55h at 2AAh and 88h at 555h select the overlay. Reads then return (5Ch + 29h × i) mod 100h, where i is the low 4 read-address bits. AAh at 555h, 55h at 2AAh, 90h at 555h and 00h restore array reads.
- R10: While the overlay is selected, the bypass-entry sequence, A0h-based program attempts and the accelerate input all have no effect.
- R11: Holding accel high outside the overlay puts the block straight into bypass mode. Two-write programs are then accepted with no unlock writes.
- R12: rd_data shows the word addressed by rd_addr on the clock edge after rd_addr is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | CMD_AW (11) | Write address; command decode uses all bits, program target uses low ARR_AW bits |
| wr_data | input | DATA_W (8) | Write data; command codes in low 8 bits |
| accel | input | 1 | Forces bypass mode when high outside the overlay |
| rd_addr | input | ARR_AW (6) | Read address |
| rd_data | output | DATA_W (8) | Registered read data from array or serial overlay |
| ready | output | 1 | High when no program is in progress |

## Verification
Read data is due one edge after rd_addr changes. The bench drives rd_addr on a falling edge and samples on the next falling edge. Ready falls on the edge that takes the address/data write, and the bench counts falling edges with ready low until it rises, expecting BUSY_CYCLES of them. A program's result lands on the edge where ready rises, so every read-back is issued only after ready is seen high. Writes that must be ignored are checked twice: ready is sampled on the falling edge just after each such write, and the target word is read back afterwards against a bench model that applies old AND new.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PGM_ARG,
    ST_BYP_IDLE,
    ST_BYP_ARG,
    ST_BYP_EXIT,
    ST_SEC_IDLE,
    ST_SEC_UNL1,
    ST_SEC_UNL2,
    ST_SEC_EXIT,
    ST_BUSY
  } seq_state_t;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_PROGRAM = 8'hA0;
  localparam logic [7:0] CODE_FASTPGM = 8'h20;
  localparam logic [7:0] CODE_OVERLAY = 8'h88;
  localparam logic [7:0] CODE_LEAVE   = 8'h90;
  localparam logic [7:0] CODE_CONFIRM = 8'h00;

  localparam int ADDR_KEY_A = 'h555;
  localparam int ADDR_KEY_B = 'h2AA;

  localparam int SN_AW    = 4;
  localparam int SN_DEPTH = 1 << SN_AW;
  localparam int SN_STEP  = 'h29;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_seq_pkg::*;
#(
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] wr_addr,
  input  logic [7:0]        wr_code,
  input  logic              accel,
  input  logic              pgm_done,
  output logic              pgm_start,
  output logic              sec_sel
);

  localparam logic [CMD_AW-1:0] A_KEY_A = CMD_AW'(ADDR_KEY_A);
  localparam logic [CMD_AW-1:0] A_KEY_B = CMD_AW'(ADDR_KEY_B);

  seq_state_t state_q, state_d;
  logic       byp_q, byp_d;
  logic       at_a, at_b;

  assign at_a = (wr_addr == A_KEY_A);
  assign at_b = (wr_addr == A_KEY_B);

  always_comb begin
    state_d   = state_q;
    byp_d     = byp_q;
    pgm_start = 1'b0;
    case (state_q)
      ST_READ: begin
        if (wr_en && at_a && wr_code == CODE_KEY_A) state_d = ST_UNL1;
      end
      ST_UNL1: begin
        if (wr_en) state_d = (at_b && wr_code == CODE_KEY_B) ? ST_UNL2 : ST_READ;
      end
      ST_UNL2: begin
        if (wr_en) begin
          if (at_a && wr_code == CODE_PROGRAM) begin
            state_d = ST_PGM_ARG;
          end else if (at_a && wr_code == CODE_FASTPGM) begin
            state_d = ST_BYP_IDLE;
            byp_d   = 1'b1;
          end else if (at_a && wr_code == CODE_OVERLAY) begin
            state_d = ST_SEC_IDLE;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_PGM_ARG, ST_BYP_ARG: begin
        if (wr_en) begin
          pgm_start = 1'b1;
          state_d   = ST_BUSY;
        end
      end
      ST_BYP_IDLE: begin
        if (wr_en) begin
          if (wr_code == CODE_PROGRAM)    state_d = ST_BYP_ARG;
          else if (wr_code == CODE_LEAVE) state_d = ST_BYP_EXIT;
        end
      end
      ST_BYP_EXIT: begin
        if (wr_en) begin
          if (wr_code == CODE_CONFIRM) begin
            state_d = ST_READ;
            byp_d   = 1'b0;
          end else begin
            state_d = ST_BYP_IDLE;
          end
        end
      end
      ST_SEC_IDLE: begin
        if (wr_en && at_a && wr_code == CODE_KEY_A) state_d = ST_SEC_UNL1;
      end
      ST_SEC_UNL1: begin
        if (wr_en) state_d = (at_b && wr_code == CODE_KEY_B) ? ST_SEC_UNL2 : ST_SEC_IDLE;
      end
      ST_SEC_UNL2: begin
        if (wr_en) state_d = (at_a && wr_code == CODE_LEAVE) ? ST_SEC_EXIT : ST_SEC_IDLE;
      end
      ST_SEC_EXIT: begin
        if (wr_en) state_d = (wr_code == CODE_CONFIRM) ? ST_READ : ST_SEC_IDLE;
      end
      ST_BUSY: begin
        if (pgm_done) state_d = byp_q ? ST_BYP_IDLE : ST_READ;
      end
      default: state_d = ST_READ;
    endcase
    // accelerate input overrides normal-mode decoding, never the overlay or busy
    if (accel && (state_q inside {ST_READ, ST_UNL1, ST_UNL2})) begin
      state_d = ST_BYP_IDLE;
      byp_d   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_READ;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byp_q   <= byp_d;
    end
  end

  assign sec_sel = (state_q inside {ST_SEC_IDLE, ST_SEC_UNL1, ST_SEC_UNL2, ST_SEC_EXIT});

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = busy && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST) busy <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/nor_prog_array.sv
module nor_prog_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;
  logic [DW-1:0] old_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    rd_q  <= mem[rd_addr];
    old_q <= mem[tgt_addr];
    if (start) begin
      tgt_addr <= start_addr;
      tgt_data <= start_data;
    end
    if (commit) mem[tgt_addr] <= old_q & tgt_data;
  end

endmodule

// File: rtl/nor_serial_rom.sv
module nor_serial_rom
  import nor_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int SN_SEED = 'h5C
) (
  input  logic             clk,
  input  logic [SN_AW-1:0] idx,
  output logic [DW-1:0]    q
);

  logic [DW-1:0] tbl [SN_DEPTH];

  for (genvar i = 0; i < SN_DEPTH; i++) begin : g_sn
    assign tbl[i] = DW'((SN_SEED + i * SN_STEP) % 256);
  end

  always_ff @(posedge clk) q <= tbl[idx];

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int CMD_AW      = 11,
  parameter int DATA_W      = 8,
  parameter int ARR_AW      = 6,
  parameter int BUSY_CYCLES = 8,
  parameter int SN_SEED     = 'h5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              accel,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);

  logic              pgm_start;
  logic              prog_done;
  logic              busy;
  logic              sec_sel;
  logic              sec_sel_q;
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] sn_q;

  nor_cmd_decode #(.CMD_AW(CMD_AW)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_code  (wr_data[7:0]),
    .accel    (accel),
    .pgm_done (prog_done),
    .pgm_start(pgm_start),
    .sec_sel  (sec_sel)
  );

  nor_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .start(pgm_start),
    .busy (busy),
    .done (prog_done)
  );

  nor_prog_array #(.AW(ARR_AW), .DW(DATA_W)) u_arr (
    .clk       (clk),
    .start     (pgm_start),
    .start_addr(wr_addr[ARR_AW-1:0]),
    .start_data(wr_data),
    .commit    (prog_done),
    .rd_addr   (rd_addr),
    .rd_q      (arr_q)
  );

  nor_serial_rom #(.DW(DATA_W), .SN_SEED(SN_SEED)) u_sn (
    .clk(clk),
    .idx(rd_addr[SN_AW-1:0]),
    .q  (sn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sec_sel_q <= 1'b0;
    else     sec_sel_q <= sec_sel;
  end

  assign rd_data = sec_sel_q ? sn_q : arr_q;
  assign ready   = ~busy;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int BUSY_CYCLES = 8
) (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic pgm_start,
  input logic prog_done,
  input logic sec_sel
);

  localparam int LW = $clog2(BUSY_CYCLES + 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)         low_cnt <= '0;
    else if (!ready) low_cnt <= low_cnt + 1'b1;
    else             low_cnt <= '0;
  end

  p_busy_window_r3: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (low_cnt < LW'(BUSY_CYCLES)));

  p_commit_at_end_r3: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> (!ready && low_cnt == LW'(BUSY_CYCLES - 1)));

  p_start_drops_ready_r3: assert property (@(posedge clk) disable iff (rst)
    pgm_start |=> !ready);

  p_busy_ignores_r4: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !pgm_start);

  p_reset_ready_r8: assert property (@(posedge clk)
    rst |=> ready);

  p_overlay_no_program_r10: assert property (@(posedge clk) disable iff (rst)
    sec_sel |-> !pgm_start);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (ready),
  .pgm_start(pgm_start),
  .prog_done(prog_done),
  .sec_sel  (sec_sel)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;

  localparam int BUSY = 8;
  localparam int SEED = 'h5C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        accel = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        ready;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [64];

  nor_cmd_seq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accel(accel), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic unlock();
    bw(11'h555, 8'hAA);
    bw(11'h2AA, 8'h55);
  endtask

  task automatic prog_std(input logic [5:0] a, input logic [7:0] d);
    unlock();
    bw(11'h555, 8'hA0);
    bw({5'd0, a}, d);
    model[a] = model[a] & d;
    wait_ready();
  endtask

  task automatic prog_byp(input logic [5:0] a, input logic [7:0] d);
    bw(11'h000, 8'hA0);
    bw({5'd0, a}, d);
    model[a] = model[a] & d;
    wait_ready();
  endtask

  task automatic expect_word(input string req, input logic [5:0] a);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, model[a]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state and erased array (R2, R3)
    chk("R3 ready after reset", ready, 1'b1);
    expect_word("R2 erased", 6'd0);

    // R1 / R3: standard program, busy length
    unlock();
    bw(11'h555, 8'hA0);
    chk("R3 ready before data", ready, 1'b1);
    bw(11'd5, 8'h3C);
    model[5] = model[5] & 8'h3C;
    n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk("R3 busy length", n, BUSY);
    expect_word("R1 standard program", 6'd5);

    // R2: program FFh over a word leaves it unchanged
    prog_std(6'd5, 8'hFF);
    expect_word("R2 no zero to one", 6'd5);

    // R2 sweep: standard programs over every word
    for (int a = 0; a < 64; a++) prog_std(6'(a), 8'((a * 37 + 11) & 8'hFF));
    // R5: enter bypass, second pass with short sequences
    unlock();
    bw(11'h555, 8'h20);
    for (int a = 0; a < 64; a++) prog_byp(6'(a), 8'(((a * 91) & 8'hFF) ^ 8'hA5));
    for (int a = 0; a < 64; a++) expect_word("R2 R5 and-merge sweep", 6'(a));

    // R6: stray command ignored in bypass, still programs
    bw(11'h000, 8'h77);
    chk("R6 stray write no busy", ready, 1'b1);
    prog_byp(6'd40, 8'h00);
    expect_word("R6 bypass after stray", 6'd40);
    // R6: 90h then non-00h stays in bypass
    bw(11'h000, 8'h90);
    bw(11'h000, 8'h12);
    prog_byp(6'd41, 8'h0F);
    expect_word("R6 bypass after aborted exit", 6'd41);
    // R6: proper exit, then short program is not accepted
    bw(11'h000, 8'h90);
    bw(11'h000, 8'h00);
    bw(11'h000, 8'hA0);
    bw(11'd42, 8'h00);
    chk("R6 no program after exit", ready, 1'b1);
    expect_word("R6 word unchanged after exit", 6'd42);

    // R7: wrong data in the third step
    unlock();
    bw(11'h555, 8'h77);
    bw(11'd43, 8'h00);
    chk("R7 bad code no busy", ready, 1'b1);
    expect_word("R7 bad code word unchanged", 6'd43);
    // R7: wrong address in the second step
    bw(11'h555, 8'hAA);
    bw(11'h123, 8'h55);
    bw(11'h555, 8'hA0);
    bw(11'd43, 8'h00);
    chk("R7 bad address no busy", ready, 1'b1);
    expect_word("R7 bad address word unchanged", 6'd43);

    // R4: command writes during busy are ignored
    unlock();
    bw(11'h555, 8'hA0);
    bw(11'd44, 8'hF0);
    model[44] = model[44] & 8'hF0;
    unlock();
    bw(11'h555, 8'hA0);
    wait_ready();
    bw(11'd45, 8'h00);
    chk("R4 no program from busy-time prefix", ready, 1'b1);
    expect_word("R4 target unchanged", 6'd45);
    expect_word("R4 running program completes", 6'd44);

    // R8: reset mid-program in bypass
    unlock();
    bw(11'h555, 8'h20);
    bw(11'h000, 8'hA0);
    bw(11'd46, 8'h00);
    chk("R8 busy before reset", ready, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 ready after reset", ready, 1'b1);
    repeat (BUSY + 2) @(negedge clk);
    expect_word("R8 aborted word unchanged", 6'd46);
    bw(11'h000, 8'hA0);
    bw(11'd47, 8'h00);
    chk("R8 bypass cleared", ready, 1'b1);
    expect_word("R8 word unchanged after reset", 6'd47);

    // R9: overlay reads
    unlock();
    bw(11'h555, 8'h88);
    for (int i = 0; i < 16; i++) begin
      rd(6'(i), v);
      chk("R9 serial byte", v, 8'((SEED + i * 'h29) % 256));
      rd(6'(i + 32), v);
      chk("R9 serial byte aliased", v, 8'((SEED + i * 'h29) % 256));
    end
    // R10: bypass entry, program and accel have no effect in overlay
    unlock();
    bw(11'h555, 8'h20);
    bw(11'h000, 8'hA0);
    bw(11'd48, 8'h00);
    chk("R10 no program in overlay", ready, 1'b1);
    accel = 1'b1;
    @(negedge clk);
    bw(11'h000, 8'hA0);
    bw(11'd48, 8'h00);
    chk("R10 accel ignored in overlay", ready, 1'b1);
    accel = 1'b0;
    rd(6'd3, v);
    chk("R10 still in overlay", v, 8'((SEED + 3 * 'h29) % 256));
    unlock();
    bw(11'h555, 8'h90);
    bw(11'h000, 8'h00);
    expect_word("R9 array after exit", 6'd48);

    // R11: accel forces bypass
    accel = 1'b1;
    @(negedge clk);
    prog_byp(6'd49, 8'h55);
    expect_word("R11 accel program", 6'd49);
    prog_byp(6'd50, 8'h0F);
    expect_word("R11 accel repeat", 6'd50);
    accel = 1'b0;
    bw(11'h000, 8'h90);
    bw(11'h000, 8'h00);

    // R12: one-cycle read latency
    rd(6'd20, v);
    @(negedge clk);
    rd_addr = 6'd21;
    #1;
    chk("R12 old word before edge", rd_data, model[20]);
    @(negedge clk);
    chk("R12 new word after edge", rd_data, model[21]);

    summary();
    $finish;
  end

endmodule